// File: doc/BRIEF.md
# UART Receive FIFO Idle Time-out Detector

This block sits beside the receive holding FIFO of a UART and raises a flag when characters are left unread while the line has gone quiet. It counts 16x-oversampling baud ticks from the last FIFO activity. A character is written into the FIFO at the centre of its first stop bit, so each write restarts the window from exactly that point. Each read also restarts the window.

Once four whole character times have gone by with the FIFO holding data, no write and no read, the flag rises. A character time counts every bit of the frame: start, data, parity and stop. Software or an interrupt unit sees the flag and drains the FIFO, even when the amount left is below the receive trigger level.

The flag stays set until one of three things happens: a read pops the FIFO, the FIFO runs empty, or FIFO mode is switched off.

Top module: `rxto_detector`

## Requirements
- R1: After a synchronous reset, `timeout_flag` is 0 and the tick count is zero. With the FIFO non-empty, exactly the full window of ticks is needed before the flag rises.
- R2: The window length in baud ticks is `frame_bits * 64`, that is 16 ticks per bit times four characters. A `frame_bits` value of 0 is treated as 1.
- R3: While `fifo_mode` and `fifo_nonempty` are both 1, the flag is set on the clock edge that samples the window-th `baud_tick` since the last restart. It is still 0 after the edge that samples one tick fewer.
- R4: A cycle with `rd_pop`=1 clears `timeout_flag` on that edge and restarts the tick count from zero.
- R5: A cycle with `wr_push`=1 restarts the tick count from zero. It does not clear a flag that is already set.
- R6: While `fifo_mode` is 0, the flag is cleared and the count is held at zero.
- R7: While `fifo_nonempty` is 0, the flag is cleared and the count is held at zero.
- R8: When `rd_pop` or `wr_push` falls in the same cycle as the tick that would complete the window, the restart wins and the flag stays 0.
- R9: Once set, the flag stays 1 through any number of further ticks and writes, as long as no read, empty FIFO or mode-off occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | UART operating with FIFOs enabled |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| wr_push | input | 1 | Character written to FIFO (at first stop-bit centre) |
| rd_pop | input | 1 | Character read from FIFO |
| baud_tick | input | 1 | One 16x-oversampling baud tick |
| frame_bits | input | FRAME_W | Bits per character frame including start and stop |
| timeout_flag | output | 1 | Receive time-out pending |

## Verification
The main collision is a restart (read or write) landing in the same cycle as the tick that completes the window. A second collision is a write arriving while the flag is already set.

Directed sequences place a read, or a write, exactly on the window-completing tick. The flag is then sampled on the following falling edge and must still be low. A further write after the flag is set must leave it high.

Random traffic with rare reads and writes and a varying frame length produces both collisions freely. Every cycle is compared against a bench model built from the requirements.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    localparam int DEF_FRAME_W       = 4;
    localparam int DEF_TICKS_PER_BIT = 16;
    localparam int DEF_CHAR_COUNT    = 4;

    // Decoded per-cycle control for the counter and flag.
    typedef struct packed {
        logic armed;    // FIFO mode on and data present
        logic restart;  // read or write this cycle
        logic clear;    // flag must drop this cycle
        logic tick;     // qualified baud tick
    } rxto_ctl_t;

    typedef enum logic [1:0] {
        RXTO_IDLE    = 2'd0,
        RXTO_COUNT   = 2'd1,
        RXTO_EXPIRED = 2'd2
    } rxto_state_e;

    function automatic int unsigned ceil_log2(input int unsigned v);
        int unsigned r;
        r = 0;
        while ((32'd1 << r) < v) r++;
        return r;
    endfunction

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rxto_event_decode.sv
module rxto_event_decode
    import rxto_pkg::*;
(
    input  logic      fifo_mode,
    input  logic      fifo_nonempty,
    input  logic      wr_push,
    input  logic      rd_pop,
    input  logic      baud_tick,
    output rxto_ctl_t ctl
);

    always_comb begin
        ctl.armed   = fifo_mode & fifo_nonempty;
        ctl.restart = wr_push | rd_pop;
        ctl.clear   = rd_pop | ~(fifo_mode & fifo_nonempty);
        ctl.tick    = baud_tick & fifo_mode & fifo_nonempty & ~(wr_push | rd_pop);
    end

endmodule

// File: rtl/rxto_window_calc.sv
module rxto_window_calc
    import rxto_pkg::*;
#(
    parameter int FRAME_W       = DEF_FRAME_W,
    parameter int TICKS_PER_BIT = DEF_TICKS_PER_BIT,
    parameter int CHAR_COUNT    = DEF_CHAR_COUNT,
    localparam int SCALE        = TICKS_PER_BIT * CHAR_COUNT,
    localparam int CNT_W        = FRAME_W + ceil_log2(SCALE) + 1
) (
    input  logic [FRAME_W-1:0] frame_bits,
    output logic [CNT_W-1:0]   window
);

    logic [FRAME_W-1:0] frame_eff;

    always_comb begin
        frame_eff = (frame_bits == '0) ? FRAME_W'(1) : frame_bits;
    end

    generate
        if (is_pow2(SCALE)) begin : g_shift
            localparam int SH = ceil_log2(SCALE);
            always_comb window = CNT_W'(frame_eff) << SH;
        end else begin : g_mult
            always_comb window = CNT_W'(frame_eff) * CNT_W'(SCALE);
        end
    endgenerate

endmodule

// File: rtl/rxto_tick_counter.sv
module rxto_tick_counter
    import rxto_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  rxto_ctl_t        ctl,
    input  logic [CNT_W-1:0] window,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W:0] next_val;

    always_comb begin
        next_val = {1'b0, count} + 1'b1;
        expire   = ctl.tick && (next_val >= {1'b0, window});
    end

    always_ff @(posedge clk) begin
        if (rst || !ctl.armed || ctl.restart) begin
            count <= '0;
        end else if (ctl.tick) begin
            count <= expire ? window : next_val[CNT_W-1:0];
        end
    end

    AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (ctl.armed && ctl.restart) |=> (count == '0)) else $error("restart"); // R4
    AST_UNARMED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ctl.armed |=> (count == '0)) else $error("unarmed"); // R6
    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
        (ctl.armed && !ctl.restart && !ctl.tick) |=> $stable(count)) else $error("step"); // R3

endmodule

// File: rtl/rxto_detector.sv
module rxto_detector
    import rxto_pkg::*;
#(
    parameter int FRAME_W       = DEF_FRAME_W,
    parameter int TICKS_PER_BIT = DEF_TICKS_PER_BIT,
    parameter int CHAR_COUNT    = DEF_CHAR_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fifo_mode,
    input  logic               fifo_nonempty,
    input  logic               wr_push,
    input  logic               rd_pop,
    input  logic               baud_tick,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               timeout_flag
);

    localparam int SCALE = TICKS_PER_BIT * CHAR_COUNT;
    localparam int CNT_W = FRAME_W + ceil_log2(SCALE) + 1;

    rxto_ctl_t        ctl;
    logic [CNT_W-1:0] window;
    logic [CNT_W-1:0] count;
    logic             expire;
    rxto_state_e      state;

    rxto_event_decode u_decode (
        .fifo_mode     (fifo_mode),
        .fifo_nonempty (fifo_nonempty),
        .wr_push       (wr_push),
        .rd_pop        (rd_pop),
        .baud_tick     (baud_tick),
        .ctl           (ctl)
    );

    rxto_window_calc #(
        .FRAME_W       (FRAME_W),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .CHAR_COUNT    (CHAR_COUNT)
    ) u_window (
        .frame_bits (frame_bits),
        .window     (window)
    );

    rxto_tick_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .window (window),
        .expire (expire),
        .count  (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RXTO_IDLE;
        end else if (ctl.clear) begin
            state <= ctl.armed ? RXTO_COUNT : RXTO_IDLE;
        end else if (expire) begin
            state <= RXTO_EXPIRED;
        end else if (state == RXTO_IDLE) begin
            state <= RXTO_COUNT;
        end
    end

    assign timeout_flag = (state == RXTO_EXPIRED);

    AST_MODE_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |=> !timeout_flag) else $error("mode"); // R6
    AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !fifo_nonempty |=> !timeout_flag) else $error("empty"); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_pop |=> !timeout_flag) else $error("read"); // R4
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> ($past(baud_tick) && !$past(wr_push))) else $error("rise"); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && fifo_mode && fifo_nonempty && !rd_pop) |=> timeout_flag) else $error("sticky"); // R9

endmodule

// File: tb/rxto_detector_tb.sv
module rxto_detector_tb;

    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          fifo_mode, fifo_nonempty, wr_push, rd_pop, baud_tick;
    logic [FW-1:0] frame_bits;
    logic          timeout_flag;

    int tests = 0;
    int fails = 0;
    int mcnt  = 0;
    bit mflag = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    rxto_detector u_dut (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .fifo_nonempty(fifo_nonempty),
        .wr_push(wr_push), .rd_pop(rd_pop), .baud_tick(baud_tick),
        .frame_bits(frame_bits), .timeout_flag(timeout_flag)
    );

    function automatic int win(input int f);
        return ((f == 0) ? 1 : f) * 64;
    endfunction

    task automatic check(input bit act, input bit exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: timeout_flag=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: inputs already driven at negedge; model advances; compare at next negedge
    task automatic step(input string req);
        @(posedge clk);
        if (!fifo_mode || !fifo_nonempty) begin
            mcnt = 0; mflag = 0;
        end else begin
            if (rd_pop) mflag = 0;
            if (rd_pop || wr_push) mcnt = 0;
            else if (baud_tick) begin
                if (mcnt + 1 >= win(frame_bits)) begin mflag = 1; mcnt = win(frame_bits); end
                else mcnt++;
            end
        end
        @(negedge clk);
        check(timeout_flag, mflag, req);
    endtask

    task automatic drive(input bit m, input bit ne, input bit w, input bit r, input bit t);
        fifo_mode = m; fifo_nonempty = ne; wr_push = w; rd_pop = r; baud_tick = t;
    endtask

    task automatic ticks(input int n, input string req);
        for (int i = 0; i < n; i++) begin drive(1, 1, 0, 0, 1); step(req); end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: timeout_flag=%0d expected=finish", timeout_flag);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        rst = 1; frame_bits = 4'd10; drive(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 0;
        check(timeout_flag, 0, "R1 reset");

        // R1/R2/R3: exact threshold, frame 10 -> 640 ticks
        drive(1, 1, 1, 0, 0); step("R1");
        ticks(639, "R3");
        check(timeout_flag, 0, "R3 one tick short");
        ticks(1, "R3");
        check(timeout_flag, 1, "R2 R3 window reached");
        // R9: more ticks keep it set, write keeps it set (R5)
        ticks(50, "R9");
        drive(1, 1, 1, 0, 1); step("R5");
        check(timeout_flag, 1, "R5 write keeps flag");
        // R4: read clears
        drive(1, 1, 0, 1, 1); step("R4");
        check(timeout_flag, 0, "R4 read clears");
        // R8: read on final tick
        ticks(639, "R8");
        drive(1, 1, 0, 1, 1); step("R8");
        check(timeout_flag, 0, "R8 read on last tick");
        ticks(639, "R8");
        drive(1, 1, 1, 0, 1); step("R8");
        check(timeout_flag, 0, "R8 write on last tick");
        ticks(639, "R5");
        check(timeout_flag, 0, "R5 write restarted window");
        ticks(1, "R5");
        check(timeout_flag, 1, "R5 expiry after restart");
        // R6: mode off clears and holds
        drive(0, 1, 0, 0, 1); step("R6");
        check(timeout_flag, 0, "R6 mode off clears");
        ticks(639, "R6");
        check(timeout_flag, 0, "R6 count restarted");
        ticks(1, "R6");
        // R7: empty clears and holds
        drive(1, 0, 0, 0, 1); step("R7");
        check(timeout_flag, 0, "R7 empty clears");
        ticks(639, "R7");
        check(timeout_flag, 0, "R7 count restarted");
        // R2: frame 0 treated as 1 -> 64 ticks
        drive(1, 1, 0, 1, 0); step("R2");
        frame_bits = 4'd0;
        ticks(63, "R2");
        check(timeout_flag, 0, "R2 zero frame short");
        ticks(1, "R2");
        check(timeout_flag, 1, "R2 zero frame window 64");

        // random traffic
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(0, 999) == 0) frame_bits = FW'($urandom_range(0, 12));
            drive($urandom_range(0, 399) != 0,
                  $urandom_range(0, 299) != 0,
                  $urandom_range(0, 499) == 0,
                  $urandom_range(0, 599) == 0,
                  $urandom_range(0, 1) == 1);
            step("R3 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule